// File: doc/BRIEF.md
# Two-Wire Serial Byte-Memory Slave

This block is a slave on a two-wire, open-drain serial bus in front of a 256-entry, 8-bit byte memory. The memory is held in on-chip registers. Both bus lines are oversampled on the system clock. The block detects start and stop conditions and matches the incoming device address against a fixed prefix and three strap pins. It then acts as a memory device: a write transaction loads a word address and then stages data bytes in a sixteen-byte page buffer. A read transaction streams bytes out from an internal address counter for as long as the master acknowledges.

The block never drives SDA high. It only asserts an open-drain enable that pulls the line low. A stop after a write with staged bytes commits the page to the array in one step. After that, a busy interval of a parameterised number of clock cycles stands in for the self-timed programming time. During that interval the device address is not acknowledged, so a master can find the end of the write by polling. A write-protect input makes the block refuse data bytes and skip the commit.

Top module: `twi_eeprom_slave`

## Requirements
- R1: While reset is asserted and right after it is released, `sda_oe_o` is low and the block is not busy. Every memory byte reads back as 0x00 after reset.
- R2: Nothing is acknowledged until a start condition has been seen. A start condition is SDA falling while SCL is high. A byte clocked without a start gets no acknowledge.
- R3: A stop condition is SDA rising while SCL is high. It releases SDA and returns the block to idle, and a new transaction after it works normally.
- R4: The block changes its SDA drive only while SCL is low. SDA stays stable across every high phase of SCL while the slave is transmitting.
- R5: The device byte is sent MSB first. Its bits 7..4 must be 1010 and its bits 3..1 must equal `strap_i[2:0]`. Bit 0 selects the direction, with 1 meaning read. On a match the slave pulls SDA low in the ninth clock; on any mismatch it leaves SDA released.
- R6: In a write transaction, the slave acknowledges the word-address byte and every data byte that follows.
- R7: Data bytes are stored at the word address. Only the low four address bits advance, and they wrap inside the sixteen-byte page, so a seventeenth byte overwrites the first. All staged bytes are committed together when the stop arrives.
- R8: After a commit, the block stays busy for `WR_CYCLES` clock cycles. While it is busy, its device address is not acknowledged. After that interval the address is acknowledged again.
- R9: A read sends the byte at the address counter MSB first. The counter then advances through all 8 bits and wraps from 0xFF to 0x00. A master acknowledge requests the next byte.
- R10: When the master does not acknowledge a read byte, the slave stops driving and sends nothing more until the next start or stop.
- R11: While `wprot_i` is high, the word-address byte is still acknowledged. Data bytes are not acknowledged, no commit or busy interval follows, and the memory is unchanged.
- R12: A write carrying only a word address, followed by a repeated start and a read, returns data starting at that word address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad (resolved open-drain level) |
| strap_i | input | 3 | Strap value for device-address bits 3..1 |
| wprot_i | input | 1 | Write protect; high refuses data bytes |
| sda_oe_o | output | 1 | Open-drain enable; high pulls SDA low |

## Verification
The assertions assume that the master behaves on the bus. SDA moves only while SCL is low, except to form a start or stop. No start or stop is issued while the slave holds SDA low. Each SCL phase lasts longer than the synchronizer delay. The bench's bus tasks keep to these rules by construction. Every data change is placed a quarter period after the SCL falling edge, and every quarter period spans several system clocks. Start and stop are issued only after the slave has released the line following an acknowledge or a master NACK.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;

  // bus-facing protocol state
  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for start
    ST_RX,     // shifting in a byte from the master
    ST_ACK,    // slave holds SDA low for the ninth clock
    ST_TX,     // slave shifts a byte out
    ST_MACK,   // slave listens for the master acknowledge
    ST_HOLD    // released, waiting for start or stop
  } bus_state_t;

  // meaning of the byte being received
  typedef enum logic [1:0] {
    RX_DEV,
    RX_WADDR,
    RX_WDATA
  } rx_kind_t;

  localparam logic [3:0] DEV_PREFIX = 4'b1010;
  localparam int         STRAP_W    = 3;

endpackage

// File: rtl/twi_line_sampler.sv
module twi_line_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_hi,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] scl_sh, sda_sh;
  logic          scl_q, sda_q;

  // synchronizer chain plus one delayed copy for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[LAST-1:0], scl_i};
      sda_sh <= {sda_sh[LAST-1:0], sda_i};
      scl_q  <= scl_sh[LAST];
      sda_q  <= sda_sh[LAST];
    end
  end

  always_comb begin
    scl_hi   = scl_sh[LAST];
    sda_lvl  = sda_sh[LAST];
    scl_rise = scl_hi & ~scl_q;
    scl_fall = ~scl_hi & scl_q;
    // SDA edges are only meaningful when SCL was high in both samples
    start_ev = scl_hi & scl_q & sda_q & ~sda_lvl;
    stop_ev  = scl_hi & scl_q & ~sda_q & sda_lvl;
  end

endmodule

// File: rtl/twi_busy_timer.sv
module twi_busy_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic busy
);

  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (go)
      cnt_n = CNT_W'(CYCLES);
    else if (cnt_q != '0)
      cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/twi_page_store.sv
module twi_page_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     buf_clr,
  input  logic                     buf_wr,
  input  logic [PAGE_W-1:0]        buf_idx,
  input  logic [DATA_W-1:0]        buf_data,
  input  logic                     commit,
  input  logic [ADDR_W-PAGE_W-1:0] page_sel,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [DATA_W-1:0]        rd_data
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int SLOTS = 1 << PAGE_W;

  logic [DATA_W-1:0] mem  [DEPTH];
  logic [DATA_W-1:0] pbuf [SLOTS];
  logic [SLOTS-1:0]  mask_q, mask_n;

  // staging mask: which page slots hold a byte for the next commit
  always_comb begin
    mask_n = mask_q;
    if (buf_clr || commit)
      mask_n = '0;
    if (buf_wr)
      mask_n[buf_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_n;
  end

  // page buffer slots, one write port each
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pbuf[s] <= '0;
      else if (buf_wr && (buf_idx == PAGE_W'(s)))
        pbuf[s] <= buf_data;
    end
  end

  // commit writes every staged slot of the selected page in one cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= '0;
    end else if (commit) begin
      for (int k = 0; k < SLOTS; k++)
        if (mask_q[k])
          mem[{page_sel, PAGE_W'(k)}] <= pbuf[k];
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave
  import twi_eeprom_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int PAGE_W      = 4,
  parameter int WR_CYCLES   = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               wprot_i,
  output logic               sda_oe_o
);

  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam int HI_W  = ADDR_W - PAGE_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sh;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= '0;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_q_n = rst_sh[1];

  logic scl_hi, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;

  twi_line_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_hi   (scl_hi),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  logic busy, commit;

  twi_busy_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_q_n),
    .go    (commit),
    .busy  (busy)
  );

  // protocol registers and their next values
  bus_state_t          st, st_n;
  rx_kind_t            rx, rx_n;
  logic [BIT_W-1:0]    bit_q, bit_n;
  logic [DATA_W-1:0]   sreg, sreg_n;
  logic [DATA_W-1:0]   txr, txr_n;
  logic [ADDR_W-1:0]   addr, addr_n;
  logic                oe, oe_n;
  logic                go_tx, go_tx_n;
  logic                mack, mack_n;
  logic                pend, pend_n;

  logic                buf_wr, buf_clr, byte_ack;
  logic [DATA_W-1:0]   rd_data;

  twi_page_store #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .PAGE_W (PAGE_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .buf_clr  (buf_clr),
    .buf_wr   (buf_wr),
    .buf_idx  (addr[PAGE_W-1:0]),
    .buf_data (sreg),
    .commit   (commit),
    .page_sel (addr[ADDR_W-1:PAGE_W]),
    .rd_addr  (addr),
    .rd_data  (rd_data)
  );

  always_comb begin
    st_n     = st;
    rx_n     = rx;
    bit_n    = bit_q;
    sreg_n   = sreg;
    txr_n    = txr;
    addr_n   = addr;
    oe_n     = oe;
    go_tx_n  = go_tx;
    mack_n   = mack;
    pend_n   = pend;
    buf_wr   = 1'b0;
    buf_clr  = 1'b0;
    commit   = 1'b0;
    byte_ack = 1'b0;

    if (start_ev) begin
      st_n    = ST_RX;
      rx_n    = RX_DEV;
      bit_n   = '0;
      oe_n    = 1'b0;
      pend_n  = 1'b0;
      buf_clr = 1'b1;
    end else if (stop_ev) begin
      st_n   = ST_IDLE;
      oe_n   = 1'b0;
      pend_n = 1'b0;
      commit = pend & ~busy;
    end else begin
      unique case (st)
        ST_RX: begin
          if (scl_rise) begin
            sreg_n = {sreg[DATA_W-2:0], sda_lvl};
            bit_n  = BIT_W'(bit_q + 1'b1);
          end else if (scl_fall && bit_q == BIT_W'(DATA_W)) begin
            unique case (rx)
              RX_DEV: begin
                byte_ack = (sreg[DATA_W-1:1] == {DEV_PREFIX, strap_i}) && !busy;
                go_tx_n  = sreg[0];
              end
              RX_WADDR: begin
                byte_ack = 1'b1;
                addr_n   = sreg[ADDR_W-1:0];
              end
              default: begin
                if (!wprot_i) begin
                  byte_ack = 1'b1;
                  buf_wr   = 1'b1;
                  pend_n   = 1'b1;
                  addr_n   = {addr[ADDR_W-1:PAGE_W],
                              PAGE_W'(addr[PAGE_W-1:0] + 1'b1)};
                end
              end
            endcase
            st_n = byte_ack ? ST_ACK : ST_HOLD;
            oe_n = byte_ack;
          end
        end

        ST_ACK: begin
          if (scl_fall) begin
            bit_n = '0;
            if (go_tx) begin
              txr_n  = rd_data;
              addr_n = ADDR_W'(addr + 1'b1);
              oe_n   = ~rd_data[DATA_W-1];
              st_n   = ST_TX;
            end else begin
              oe_n = 1'b0;
              st_n = ST_RX;
              rx_n = (rx == RX_DEV) ? RX_WADDR : RX_WDATA;
            end
          end
        end

        ST_TX: begin
          if (scl_fall) begin
            if (bit_q == BIT_W'(DATA_W - 1)) begin
              oe_n  = 1'b0;
              bit_n = '0;
              st_n  = ST_MACK;
            end else begin
              txr_n = {txr[DATA_W-2:0], 1'b0};
              oe_n  = ~txr[DATA_W-2];
              bit_n = BIT_W'(bit_q + 1'b1);
            end
          end
        end

        ST_MACK: begin
          if (scl_rise) begin
            mack_n = ~sda_lvl;
          end else if (scl_fall) begin
            if (mack) begin
              txr_n  = rd_data;
              addr_n = ADDR_W'(addr + 1'b1);
              oe_n   = ~rd_data[DATA_W-1];
              st_n   = ST_TX;
            end else begin
              st_n = ST_HOLD;
            end
          end
        end

        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      st    <= ST_IDLE;
      rx    <= RX_DEV;
      bit_q <= '0;
      sreg  <= '0;
      txr   <= '0;
      addr  <= '0;
      oe    <= 1'b0;
      go_tx <= 1'b0;
      mack  <= 1'b0;
      pend  <= 1'b0;
    end else begin
      st    <= st_n;
      rx    <= rx_n;
      bit_q <= bit_n;
      sreg  <= sreg_n;
      txr   <= txr_n;
      addr  <= addr_n;
      oe    <= oe_n;
      go_tx <= go_tx_n;
      mack  <= mack_n;
      pend  <= pend_n;
    end
  end

  assign sda_oe_o = oe;

endmodule

// File: rtl/twi_eeprom_slave_chk.sv
module twi_eeprom_slave_chk
  import twi_eeprom_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       scl_hi,
  input logic       stop_ev,
  input logic       oe,
  input logic       commit,
  input logic       busy,
  input bus_state_t st
);

  // a stop always leaves the line released on the next cycle
  assert_stop_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !oe);

  // the slave's drive never moves while the sampled clock is high
  assert_drive_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe) |-> !scl_hi);

  // a commit starts the busy interval
  assert_commit_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> busy);

  // the line is pulled low only in the acknowledge or transmit phases
  assert_drive_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> (st == ST_ACK || st == ST_TX));

  // while waiting for the master acknowledge the slave is silent
  assert_mack_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MACK) |-> !oe);

endmodule

bind twi_eeprom_slave twi_eeprom_slave_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .scl_hi  (scl_hi),
  .stop_ev (stop_ev),
  .oe      (sda_oe_o),
  .commit  (commit),
  .busy    (busy),
  .st      (st)
);

// File: tb/twi_eeprom_slave_test.sv
`timescale 1ns/1ps
module twi_eeprom_slave_test;

  localparam int WR_CYC = 400;
  localparam int Q      = 6;
  localparam logic [7:0] DEV_W = 8'hAA;  // 1010 101 0
  localparam logic [7:0] DEV_R = 8'hAB;  // 1010 101 1

  // {word address, data}
  localparam logic [15:0] VEC [8] = '{
    16'h00_11, 16'hFF_5A, 16'h01_C3, 16'h80_3C,
    16'h7F_E7, 16'h55_AA, 16'hAA_55, 16'h10_01
  };

  logic clk = 1'b0;
  logic rst_n;
  logic scl, m_sda, wprot;
  logic [2:0] strap;
  logic oe;
  logic sda_line;

  always #2.5 clk = ~clk;

  assign sda_line = m_sda & ~oe;

  twi_eeprom_slave #(.WR_CYCLES(WR_CYC)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl),
    .sda_i    (sda_line),
    .strap_i  (strap),
    .wprot_i  (wprot),
    .sda_oe_o (oe)
  );

  int total = 0;
  int bad   = 0;
  logic [7:0] rbuf [16];
  logic steady;

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq();
    scl   = 1'b1; wq();
    m_sda = 1'b0; wq();
    scl   = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq();
    scl   = 1'b1; wq();
    m_sda = 1'b1; wq();
  endtask

  task automatic clock_bit(input logic b, output logic r);
    m_sda = b; wq();
    scl = 1'b1; wq();
    r = sda_line; wq();
    if (sda_line != r) steady = 1'b0;
    scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], r);
    clock_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    logic r;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      clock_bit(1'b1, r);
      d = {d[6:0], r};
    end
    clock_bit(~give_ack, r);
  endtask

  task automatic poll_ready(output int tries);
    logic a;
    tries = 0;
    a = 1'b0;
    while (!a && tries < 50) begin
      tries++;
      bus_start();
      send_byte(DEV_W, a);
      bus_stop();
    end
  endtask

  // word-address write, repeated start, n reads
  task automatic rd_seq(input logic [7:0] a, input int n);
    logic ack;
    bus_start();
    send_byte(DEV_W, ack); chk("R12 dev ack", ack, 1);
    send_byte(a, ack);     chk("R12 waddr ack", ack, 1);
    bus_start();
    send_byte(DEV_R, ack); chk("R12 read dev ack", ack, 1);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic ack;
    logic [7:0] d;
    int tries;
    rst_n = 1'b0; scl = 1'b1; m_sda = 1'b1; wprot = 1'b0; strap = 3'b101;
    steady = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 oe in reset", oe, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 oe after reset", oe, 0);
    poll_ready(tries);
    chk("R1 not busy after reset", tries, 1);
    rd_seq(8'h40, 1);
    chk("R1 memory cleared", rbuf[0], 8'h00);

    // table: write one byte, poll, read back
    for (int i = 0; i < 8; i++) begin
      bus_start();
      send_byte(DEV_W, ack);          chk("R5 dev ack", ack, 1);
      send_byte(VEC[i][15:8], ack);   chk("R6 waddr ack", ack, 1);
      send_byte(VEC[i][7:0], ack);    chk("R6 data ack", ack, 1);
      bus_stop();
      chk("R3 released after stop", oe, 0);
      poll_ready(tries);
      chk("R8 busy after write", int'(tries > 1), 1);
      rd_seq(VEC[i][15:8], 1);
      chk("R12 read back", rbuf[0], VEC[i][7:0]);
    end

    // R2: byte without start
    send_byte(DEV_W, ack);
    chk("R2 no ack without start", ack, 0);
    bus_stop();

    // R5: wrong strap and wrong prefix
    bus_start(); send_byte(8'hA4, ack); bus_stop();
    chk("R5 strap mismatch nack", ack, 0);
    bus_start(); send_byte(8'hBA, ack); bus_stop();
    chk("R5 prefix mismatch nack", ack, 0);

    // R7: seventeen bytes into page 0x30
    bus_start();
    send_byte(DEV_W, ack);
    send_byte(8'h30, ack);
    for (int i = 0; i < 17; i++) begin
      send_byte(8'h80 + 8'(i), ack);
      chk("R6 page byte ack", ack, 1);
    end
    bus_stop();
    bus_start(); send_byte(DEV_W, ack); bus_stop();
    chk("R8 address nack while busy", ack, 0);
    poll_ready(tries);
    chk("R8 ready again", int'(tries < 50), 1);
    rd_seq(8'h30, 16);
    chk("R7 wrapped byte", rbuf[0], 8'h90);
    for (int i = 1; i < 16; i++) chk("R7 page byte", rbuf[i], 8'h80 + i);

    // R9: counter wrap 0xFF -> 0x00
    rd_seq(8'hFF, 3);
    chk("R9 byte at FF", rbuf[0], 8'h5A);
    chk("R9 wrap to 00", rbuf[1], 8'h11);
    chk("R9 then 01", rbuf[2], 8'hC3);

    // R10: master NACK ends transmission
    bus_start();
    send_byte(DEV_W, ack);
    send_byte(8'h80, ack);
    bus_start();
    send_byte(DEV_R, ack);
    recv_byte(1'b0, d);
    chk("R10 first byte", d, 8'h3C);
    recv_byte(1'b0, d);
    chk("R10 silent after nack", d, 8'hFF);
    bus_stop();

    // R11: write protect
    wprot = 1'b1;
    bus_start();
    send_byte(DEV_W, ack);
    send_byte(8'h01, ack); chk("R11 waddr ack under protect", ack, 1);
    send_byte(8'h99, ack); chk("R11 data nack under protect", ack, 0);
    bus_stop();
    poll_ready(tries);
    chk("R11 no busy interval", tries, 1);
    wprot = 1'b0;
    rd_seq(8'h01, 1);
    chk("R11 memory unchanged", rbuf[0], 8'hC3);

    chk("R4 SDA stable while SCL high", steady, 1);

    // R1: reset in mid-read clears drive and memory
    bus_start();
    send_byte(DEV_W, ack);
    send_byte(8'h7F, ack);
    bus_start();
    send_byte(DEV_R, ack);
    wq();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 oe dropped by reset", oe, 0);
    scl = 1'b1; m_sda = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    rd_seq(8'h00, 1);
    chk("R1 memory cleared by reset", rbuf[0], 8'h00);

    report();
  end

endmodule